// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs single accesses to one asynchronous external SRAM, PSRAM or NOR device. Each access goes through four phases: the address is put on the pins, it is held, data moves while output enable or write enable is low, and then the bus rests before the next access. The host raises a request with a direction, address, write data and a two-bit byte-lane mask. It keeps the request steady until the block returns a one-clock ready pulse. In the ready cycle the host either removes the request or puts the next one in its place.

Two 32-bit timing words set the phase lengths, one for reads and one for writes. The block latches the word that matches the direction when it accepts a request, so changing a word in the middle of an access has no effect on that access. The memory data bus appears as separate input, output and drive-enable ports, ready for a pad ring.

Top module: `async_mem_ctrl`

## Requirements
- R1: Timing word layout: bits 3:0 are setup (S), bits 7:4 are hold (H), bits 15:8 are the data field, bits 19:16 are turnaround (T), and bits 29:28 are the mode. Reads use `rdTiming`. Writes use `wrTiming`.
- R2: A read drives `memCsN` low for S+H+D consecutive clocks, where D = data field + 1. `memOeN` is low for exactly the last D of those clocks.
- R3: A setup or hold field of 0 behaves like 1, so every phase lasts at least one clock.
- R4: `memAdvN` is low for exactly one clock per access, the first clock in which `memCsN` is low.
- R5: During a read, `memWeN` stays high and `memDataOe` stays low.
- R6: During a write, `memOeN` stays high and `memWeN` is low for exactly the last D clocks of the access. `memDataOe` is high and `memDataOut` equals the write data for the last H+D clocks, starting with the first hold clock.
- R7: `memLaneN` is the inverse of the request mask (bit 0 is the low byte) while `memCsN` is low, and it is 2'b11 while `memCsN` is high.
- R8: `memAddr` equals the request address and does not change while `memCsN` is low.
- R9: `memDataIn` is captured on the clock edge that ends the last data clock of a read. `ready` pulses high for one clock right after the access, and `rdData` is valid in that clock.
- R10: When the next request is already waiting in the ready cycle, `memCsN` stays high for exactly T+2 clocks between the two accesses.
- R11: A request whose selected timing word has a mode field other than 3 is not accepted. `memCsN` stays high and `ready` stays low.
- R12: After reset all strobes are high, `memLaneN` is 2'b11, `memDataOe` is low and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 26 | Access address |
| reqWdata | input | 16 | Write data |
| reqLaneMask | input | 2 | Byte lanes to enable, bit 0 = low byte |
| rdTiming | input | 32 | Timing word for reads |
| wrTiming | input | 32 | Timing word for writes |
| ready | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Captured read data |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAdvN | output | 1 | Address-valid strobe, active low |
| memLaneN | output | 2 | Byte-lane enables, active low |
| memAddr | output | 26 | Memory address |
| memDataOut | output | 16 | Data driven toward memory |
| memDataOe | output | 1 | Drive enable for memDataOut |
| memDataIn | input | 16 | Data returned by memory |

## Verification
The bench changes the memory's returned data on every clock of output enable. A design that captures one clock too early or too late therefore returns a wrong word. It runs setup and hold fields of zero; a design that skips a phase would shorten chip select or move address-valid. It times the chip-select gap between back-to-back accesses with turnaround values 0 and 5, which exposes an off-by-one in the rest counter. It presents a read with the mode field set to something other than mode D and checks that chip select never falls. It also runs a write whose read timing word differs from its write timing word, which catches a design that uses the wrong word.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int SETUP_LSB = 0;
  localparam int SETUP_W   = 4;
  localparam int HOLD_LSB  = 4;
  localparam int HOLD_W    = 4;
  localparam int DATA_LSB  = 8;
  localparam int DATA_FW   = 8;
  localparam int TURN_LSB  = 16;
  localparam int TURN_W    = 4;
  localparam int MODE_LSB  = 28;
  localparam int MODE_W    = 2;
  localparam logic [MODE_W-1:0] MODE_SEQ_D = 2'd3;
  localparam int CNT_W = DATA_FW;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_DATA, PH_DONE, PH_TURN
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [DATA_FW-1:0] data;
    logic [TURN_W-1:0]  turn;
    logic [MODE_W-1:0]  mode;
  } timing_t;

  typedef struct packed {
    logic latchReq;
    logic capture;
    logic csOn;
    logic advOn;
    logic oeOn;
    logic weOn;
    logic driveOn;
    logic readyOn;
  } strobe_t;

  function automatic timing_t unpackTiming(input logic [31:0] word);
    timing_t t;
    t.setup = word[SETUP_LSB +: SETUP_W];
    t.hold  = word[HOLD_LSB  +: HOLD_W];
    t.data  = word[DATA_LSB  +: DATA_FW];
    t.turn  = word[TURN_LSB  +: TURN_W];
    t.mode  = word[MODE_LSB  +: MODE_W];
    return t;
  endfunction
endpackage

// File: rtl/amc_ctrl.sv
module amc_ctrl
  import amc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] rdTiming,
  input  logic [31:0] wrTiming,
  output strobe_t     strb
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             firstCyc;
  timing_t          tim;
  timing_t          selTim;
  logic             accept;

  function automatic logic [CNT_W-1:0] lenMinus1(input logic [3:0] f);
    return (f == 4'd0) ? '0 : CNT_W'(f) - CNT_W'(1);
  endfunction

  assign selTim = unpackTiming(reqWrite ? wrTiming : rdTiming);
  assign accept = (phase == PH_IDLE) && reqValid && (selTim.mode == MODE_SEQ_D);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      firstCyc <= 1'b0;
      tim      <= '0;
    end else begin
      firstCyc <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_SETUP;
          isWrite  <= reqWrite;
          tim      <= selTim;
          cnt      <= lenMinus1(selTim.setup);
          firstCyc <= 1'b1;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= lenMinus1(tim.hold);
        end else cnt <= cnt - CNT_W'(1);
        PH_HOLD: if (cnt == '0) begin
          phase <= PH_DATA;
          cnt   <= tim.data;
        end else cnt <= cnt - CNT_W'(1);
        PH_DATA: if (cnt == '0) phase <= PH_DONE;
                 else cnt <= cnt - CNT_W'(1);
        PH_DONE: if (tim.turn == '0) phase <= PH_IDLE;
                 else begin
                   phase <= PH_TURN;
                   cnt   <= CNT_W'(tim.turn) - CNT_W'(1);
                 end
        PH_TURN: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchReq = accept;
    strb.csOn     = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);
    strb.advOn    = (phase == PH_SETUP) && firstCyc;
    strb.oeOn     = (phase == PH_DATA) && !isWrite;
    strb.weOn     = (phase == PH_DATA) && isWrite;
    strb.driveOn  = ((phase == PH_HOLD) || (phase == PH_DATA)) && isWrite;
    strb.capture  = (phase == PH_DATA) && (cnt == '0) && !isWrite;
    strb.readyOn  = (phase == PH_DONE);
  end

  // R4: address-valid lasts a single clock
  a_r4_adv_once: assert property (@(posedge clk) disable iff (!rstN)
    strb.advOn |=> !strb.advOn);
  // R9: ready is a one-clock pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.readyOn |=> !strb.readyOn);
  // R11: an access only runs with a mode-D timing word latched
  a_r11_mode_d_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.advOn |-> (tim.mode == MODE_SEQ_D));
  // R10: turnaround leads only to idle, never straight into an access
  a_r10_turn_exit: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TURN) |=> (phase == PH_TURN) || (phase == PH_IDLE));
endmodule

// File: rtl/amc_datapath.sv
module amc_datapath
  import amc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneMask,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memAdvN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strb.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqLaneMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (strb.capture) rdataQ <= memDataIn;
  end

  assign memCsN     = !strb.csOn;
  assign memOeN     = !strb.oeOn;
  assign memWeN     = !strb.weOn;
  assign memAdvN    = !strb.advOn;
  assign memAddr    = addrQ;
  assign memDataOe  = strb.driveOn;
  assign memDataOut = strb.driveOn ? wdataQ : '0;
  assign ready      = strb.readyOn;
  assign rdData     = rdataQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memLaneN[g] = !(strb.csOn && maskQ[g]);
  end

  // R8: address held across the chip-select window
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));
  // R7: no lane enabled while deselected
  a_r7_lanes_idle: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> (memLaneN == '1));
  // R6: data is driven whenever write enable is low
  a_r6_drive_with_we: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDataOe);
  // R9: read data only moves on a capture
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdData));
  // R5: no drive during output enable
  a_r5_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memDataOe));
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneMask,
  input  logic [31:0]       rdTiming,
  input  logic [31:0]       wrTiming,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memAdvN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);
  strobe_t strb;

  amc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rdTiming(rdTiming), .wrTiming(wrTiming), .strb(strb)
  );

  amc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqLaneMask(reqLaneMask), .memDataIn(memDataIn),
    .ready(ready), .rdData(rdData), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memAdvN(memAdvN), .memLaneN(memLaneN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe)
  );
endmodule

// File: tb/tb_async_mem_ctrl.sv
module tb_async_mem_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [25:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqLaneMask = '0;
  logic [31:0] rdTiming = '0;
  logic [31:0] wrTiming = '0;
  logic        ready;
  logic [15:0] rdData;
  logic        memCsN, memOeN, memWeN, memAdvN, memDataOe;
  logic [1:0]  memLaneN;
  logic [25:0] memAddr;
  logic [15:0] memDataOut;
  logic [15:0] memDataIn = 16'hDEAD;

  int total = 0;
  int bad = 0;
  int hiRun = 0;
  int lastGap = -1;
  int oeK = 0;
  logic [15:0] rdBase = '0;

  always #5 clk = ~clk;

  async_mem_ctrl dut (.*);

  function automatic logic [31:0] mkWord(int mode, int turn, int dat, int hld, int st);
    return {2'b00, 2'(mode), 8'h00, 4'(turn), 8'(dat), 4'(hld), 4'(st)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model: new data every output-enable clock; chip-select gap meter
  always @(negedge clk) begin
    if (!memOeN) begin oeK = oeK + 1; memDataIn = rdBase + 16'(oeK); end
    else begin oeK = 0; memDataIn = 16'hDEAD; end
    if (memCsN) hiRun = hiRun + 1;
    else if (hiRun > 0) begin lastGap = hiRun; hiRun = 0; end
  end

  task automatic runAccess(input bit wr, input logic [25:0] a, input logic [15:0] wd,
                           input logic [1:0] msk, input bit chain);
    logic [31:0] w = wr ? wrTiming : rdTiming;
    int s = (w[3:0] == 0) ? 1 : int'(w[3:0]);
    int h = (w[7:4] == 0) ? 1 : int'(w[7:4]);
    int d = int'(w[15:8]) + 1;
    int csCnt = 0, advCnt = 0, advIdx = 0, oeCnt = 0, oeIdx = 0;
    int weCnt = 0, weIdx = 0, drvCnt = 0, drvIdx = 0;
    int addrErr = 0, laneErr = 0, dataErr = 0, n = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqLaneMask = msk;
    rdBase = 16'h1000 + 16'(a[7:0]);
    do begin
      @(negedge clk); n++;
      if (!memCsN) begin
        csCnt++;
        if (!memAdvN) begin advCnt++; advIdx = csCnt; end
        if (!memOeN) begin oeCnt++; if (oeIdx == 0) oeIdx = csCnt; end
        if (!memWeN) begin
          weCnt++; if (weIdx == 0) weIdx = csCnt;
        end
        if (memDataOe) begin
          drvCnt++; if (drvIdx == 0) drvIdx = csCnt;
          if (memDataOut != wd) dataErr++;
        end
        if (memAddr != a) addrErr++;
        if (memLaneN != ~msk) laneErr++;
      end
    end while (!ready && n < 1000);
    chk(ready, "R9", "ready seen", int'(ready), 1);
    chk(csCnt == s + h + d, wr ? "R6" : "R2", "cs low clocks", csCnt, s + h + d);
    chk(advCnt == 1 && advIdx == 1, "R4", "adv clocks/pos", advCnt * 10 + advIdx, 11);
    chk(addrErr == 0, "R8", "address mismatches", addrErr, 0);
    chk(laneErr == 0 && memLaneN == 2'b11, "R7", "lane errors", laneErr, 0);
    if (wr) begin
      chk(oeCnt == 0, "R6", "oe clocks in write", oeCnt, 0);
      chk(weCnt == d && weIdx == s + h + 1, "R6", "we clocks", weCnt * 100 + weIdx,
          d * 100 + s + h + 1);
      chk(drvCnt == h + d && drvIdx == s + 1, "R6", "drive clocks",
          drvCnt * 100 + drvIdx, (h + d) * 100 + s + 1);
      chk(dataErr == 0, "R6", "write data errors", dataErr, 0);
    end else begin
      chk(oeCnt == d && oeIdx == s + h + 1, "R2", "oe clocks", oeCnt * 100 + oeIdx,
          d * 100 + s + h + 1);
      chk(weCnt == 0 && drvCnt == 0, "R5", "we/drive in read", weCnt + drvCnt, 0);
      chk(rdData == rdBase + 16'(d), "R9", "captured data", int'(rdData),
          int'(rdBase + 16'(d)));
    end
    if (!chain) reqValid = 1'b0;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(memCsN && memOeN && memWeN && memAdvN, "R12", "strobes high",
        int'({memCsN, memOeN, memWeN, memAdvN}), 15);
    chk(memLaneN == 2'b11 && !memDataOe && !ready, "R12", "lanes/drive/ready",
        int'({memLaneN, memDataOe, ready}), 12);
  endtask

  task automatic testBasicRead();
    rdTiming = mkWord(3, 1, 3, 1, 2);
    runAccess(1'b0, 26'h2A5_5AA1, 16'h0, 2'b11, 1'b0);
    idle(4);
  endtask

  task automatic testWriteSelect();
    // R1: write must use the write word, not the read word
    rdTiming = mkWord(3, 1, 9, 7, 6);
    wrTiming = mkWord(3, 1, 1, 2, 3);
    runAccess(1'b1, 26'h013_3F0C, 16'hBEEF, 2'b11, 1'b0);
    idle(4);
    runAccess(1'b0, 26'h0000_040, 16'h0, 2'b11, 1'b0);
    idle(4);
  endtask

  task automatic testZeroFields();
    // R3: zero setup/hold read and write
    rdTiming = mkWord(3, 0, 0, 0, 0);
    wrTiming = mkWord(3, 0, 0, 0, 0);
    runAccess(1'b0, 26'h3FF_FFFF, 16'h0, 2'b11, 1'b0);
    idle(3);
    runAccess(1'b1, 26'h000_0001, 16'h1234, 2'b11, 1'b0);
    idle(3);
  endtask

  task automatic testLanes();
    wrTiming = mkWord(3, 2, 2, 1, 1);
    runAccess(1'b1, 26'h100_0010, 16'h00A5, 2'b01, 1'b0);
    idle(3);
    runAccess(1'b1, 26'h100_0011, 16'h5A00, 2'b10, 1'b0);
    idle(3);
  endtask

  task automatic testTurnaround(input int t);
    rdTiming = mkWord(3, t, 1, 1, 1);
    runAccess(1'b0, 26'h000_0100, 16'h0, 2'b11, 1'b1);
    runAccess(1'b0, 26'h000_0200, 16'h0, 2'b11, 1'b0);
    chk(lastGap == t + 2, "R10", "cs high gap", lastGap, t + 2);
    idle(t + 4);
  endtask

  task automatic testModeIgnored();
    int csLow = 0, rdy = 0;
    rdTiming = mkWord(0, 0, 1, 1, 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 26'h55; reqLaneMask = 2'b11;
    repeat (30) begin
      @(negedge clk);
      if (!memCsN) csLow++;
      if (ready) rdy++;
    end
    reqValid = 1'b0;
    rdTiming = mkWord(3, 0, 1, 1, 1);
    repeat (5) begin
      @(negedge clk);
      if (!memCsN) csLow++;
    end
    chk(csLow == 0, "R11", "cs low clocks with bad mode", csLow, 0);
    chk(rdy == 0, "R11", "ready with bad mode", rdy, 0);
  endtask

  task automatic testLongData();
    rdTiming = mkWord(3, 3, 40, 5, 15);
    runAccess(1'b0, 26'h2AB_CDEF, 16'h0, 2'b11, 1'b0);
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    idle(2);
    testBasicRead();
    testWriteSelect();
    testZeroFields();
    testLanes();
    testTurnaround(0);
    testTurnaround(5);
    testModeIgnored();
    testLongData();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule